// File: doc/BRIEF.md
# Register-to-Serial-EEPROM Product Data Bridge

This block lets a host reach product data held in a small three-wire serial EEPROM through two 32-bit registers. One register holds a byte address and a single flag bit in bit 31. The other holds one 32-bit data word. The host starts a transfer with a single write to the address register, and the value of the flag in that write picks the direction. A flag of 1 copies the data register into the EEPROM. A flag of 0 fills the data register from the EEPROM. The block then flips the flag to signal that the transfer is done. This means a finished write reads back 0, and a finished read reads back 1.

The EEPROM is organised as 16-bit words. Each transfer moves two neighbouring words. The block drives the serial clock by dividing the system clock. It sends start, opcode, address and data frames, shifting each most-significant bit first. Before every word write it sends an enable-write frame. After every word write it holds off the next frame until the device signals that it is ready again.

Top module: `vpd_eeprom_bridge`

## Requirements
- R1: After reset the address register reads 0 (flag 0, address 0), the data register reads 0, and chip select is low.
- R2: A host write to the address register with bit 31 = 1 starts a store. Data bits 15:0 go to word W = byte address >> 1, and bits 31:16 go to word W+1. The flag then clears to 0 and the data register keeps its value.
- R3: A host write to the address register with bit 31 = 0 starts a load. The data register becomes {word W+1, word W}, and the flag then sets to 1.
- R4: Bit 0 of the byte address is ignored. Word W+1 wraps modulo 2^AW. Bits 30 down to AW+1 of the address register read as 0.
- R5: Every read or write frame is a start bit 1, then an opcode (10 = read, 01 = write), then AW address bits, then 16 data bits, all MSB first. On a read, the 16 data bits are taken on the 16 rising serial-clock edges that follow the last address bit.
- R6: Before each word store the block sends a 1+2+AW bit enable-write frame: start 1, opcode 00, address bits 11 followed by zeros. Two such frames are sent per store.
- R7: After each word store, chip select stays low for at least one rising serial-clock edge. Chip select is then held high until data-out is sampled high. No new frame starts before that point.
- R8: A host write to either register while a transfer runs is ignored. The address register and the data register keep their values.
- R9: The serial clock period is DIV system clocks, with DIV/2 clocks high. Data-in and chip select change only on a falling serial-clock edge.
- R10: Chip select is low whenever no transfer is running.
- R11: While a transfer runs, the flag holds the value written by the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr_we | input | 1 | Write strobe for the address/flag register |
| host_data_we | input | 1 | Write strobe for the data register |
| host_wdata | input | 32 | Host write value |
| vpd_addr_q | output | 32 | Address/flag register readback |
| vpd_data_q | output | 32 | Data register readback |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |

## Verification
The cycle-level assertions check several properties on every cycle. Data-in and chip select may move only on a falling serial-clock edge. Chip select stays low when idle. The flag holds the command value throughout a transfer and shows the opposite value in the cycle the transfer ends. Host writes during a transfer leave the address register untouched. Other behaviour only the bench scenarios can show: the word packing and wrap-around, the opcode and bit order, one enable-write frame per word, the ready poll, and the clock period. These are checked through a behavioural EEPROM model that refuses stores that were not enabled and records any frame started while it is busy.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_EWEN, S_EWEN_W, S_WR, S_WR_W, S_POLL, S_POLL_W,
    S_RD, S_RD_W, S_NEXT, S_FIN
  } seq_state_t;

  typedef enum logic [2:0] {
    E_IDLE, E_GAP, E_SHIFT, E_PGAP, E_POLL, E_PEND
  } eng_state_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_EWEN  = 2'b00;
endpackage

// File: rtl/vpd_sk_gen.sv
module vpd_sk_gen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic sk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sk_q, sk_d;

  always_comb begin
    rise_tick = (cnt_q == CW'(HALF - 1));
    fall_tick = (cnt_q == CW'(DIV - 1));
    cnt_d     = fall_tick ? '0 : cnt_q + 1'b1;
    sk_d      = sk_q;
    if (rise_tick)      sk_d = 1'b1;
    else if (fall_tick) sk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sk_q  <= sk_d;
    end
  end

  assign sk = sk_q;
endmodule

// File: rtl/vpd_uwire.sv
module vpd_uwire
  import vpd_pkg::*;
#(
  parameter int FW = 25,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_tick,
  input  logic          fall_tick,
  input  logic          go_frame,
  input  logic          go_poll,
  input  logic [FW-1:0] tx_vec,
  input  logic [LW-1:0] tx_len,
  input  logic          ee_do,
  output logic          cs,
  output logic          di,
  output logic [15:0]   rx_word,
  output logic          done
);
  eng_state_t    st_q, st_d;
  logic [FW-1:0] sreg_q, sreg_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          cs_q, cs_d, di_q, di_d, done_q, done_d;
  logic [15:0]   rx_q, rx_d;

  always_comb begin
    st_d   = st_q;
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    cs_d   = cs_q;
    di_d   = di_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    unique case (st_q)
      E_IDLE: begin
        if (go_frame) begin
          st_d   = E_GAP;
          sreg_d = tx_vec;
          cnt_d  = tx_len;
        end else if (go_poll) begin
          st_d = E_PGAP;
        end
      end
      E_GAP: begin
        if (fall_tick) begin
          st_d   = E_SHIFT;
          cs_d   = 1'b1;
          di_d   = sreg_q[FW-1];
          sreg_d = {sreg_q[FW-2:0], 1'b0};
          cnt_d  = cnt_q - 1'b1;
        end
      end
      E_SHIFT: begin
        if (rise_tick) rx_d = {rx_q[14:0], ee_do};
        if (fall_tick) begin
          if (cnt_q == '0) begin
            cs_d   = 1'b0;
            di_d   = 1'b0;
            st_d   = E_IDLE;
            done_d = 1'b1;
          end else begin
            di_d   = sreg_q[FW-1];
            sreg_d = {sreg_q[FW-2:0], 1'b0};
            cnt_d  = cnt_q - 1'b1;
          end
        end
      end
      E_PGAP: begin
        if (fall_tick) begin
          cs_d = 1'b1;
          st_d = E_POLL;
        end
      end
      E_POLL: begin
        if (rise_tick && ee_do) st_d = E_PEND;
      end
      E_PEND: begin
        if (fall_tick) begin
          cs_d   = 1'b0;
          st_d   = E_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      sreg_q <= '0;
      cnt_q  <= '0;
      cs_q   <= 1'b0;
      di_q   <= 1'b0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      cs_q   <= cs_d;
      di_q   <= di_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign cs      = cs_q;
  assign di      = di_q;
  assign rx_word = rx_q;
  assign done    = done_q;
endmodule

// File: rtl/vpd_seq.sv
module vpd_seq
  import vpd_pkg::*;
#(
  parameter int AW = 6,
  parameter int FW = 25,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_wr,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   wdata,
  input  logic          eng_done,
  output logic          go_frame,
  output logic          go_poll,
  output logic [FW-1:0] tx_vec,
  output logic [LW-1:0] tx_len,
  output logic          busy,
  output logic          done,
  output logic          rd_load,
  output logic          rd_hi
);
  seq_state_t    st_q, st_d;
  logic          dir_q, dir_d, widx_q, widx_d;
  logic [AW-1:0] base_q, base_d, cur_addr;
  logic [15:0]   cur_data;

  always_comb begin
    cur_addr = base_q + {{(AW-1){1'b0}}, widx_q};
    cur_data = widx_q ? wdata[31:16] : wdata[15:0];
  end

  always_comb begin
    st_d     = st_q;
    dir_d    = dir_q;
    widx_d   = widx_q;
    base_d   = base_q;
    go_frame = 1'b0;
    go_poll  = 1'b0;
    tx_vec   = '0;
    tx_len   = '0;
    done     = 1'b0;
    rd_load  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          dir_d  = dir_wr;
          base_d = base_addr;
          widx_d = 1'b0;
          st_d   = dir_wr ? S_EWEN : S_RD;
        end
      end
      S_EWEN: begin
        go_frame = 1'b1;
        tx_vec   = {1'b1, OP_EWEN, 2'b11, {(AW-2){1'b0}}, 16'h0000};
        tx_len   = LW'(3 + AW);
        st_d     = S_EWEN_W;
      end
      S_EWEN_W: if (eng_done) st_d = S_WR;
      S_WR: begin
        go_frame = 1'b1;
        tx_vec   = {1'b1, OP_WRITE, cur_addr, cur_data};
        tx_len   = LW'(FW);
        st_d     = S_WR_W;
      end
      S_WR_W: if (eng_done) st_d = S_POLL;
      S_POLL: begin
        go_poll = 1'b1;
        st_d    = S_POLL_W;
      end
      S_POLL_W: if (eng_done) st_d = S_NEXT;
      S_RD: begin
        go_frame = 1'b1;
        tx_vec   = {1'b1, OP_READ, cur_addr, 16'h0000};
        tx_len   = LW'(FW);
        st_d     = S_RD_W;
      end
      S_RD_W: begin
        if (eng_done) begin
          rd_load = 1'b1;
          st_d    = S_NEXT;
        end
      end
      S_NEXT: begin
        if (widx_q) begin
          st_d = S_FIN;
        end else begin
          widx_d = 1'b1;
          st_d   = dir_q ? S_EWEN : S_RD;
        end
      end
      S_FIN: begin
        done = 1'b1;
        st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      dir_q  <= 1'b0;
      widx_q <= 1'b0;
      base_q <= '0;
    end else begin
      st_q   <= st_d;
      dir_q  <= dir_d;
      widx_q <= widx_d;
      base_q <= base_d;
    end
  end

  assign busy  = (st_q != S_IDLE);
  assign rd_hi = widx_q;
endmodule

// File: rtl/vpd_eeprom_bridge.sv
module vpd_eeprom_bridge
  import vpd_pkg::*;
#(
  parameter int AW  = 6,
  parameter int DIV = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_addr_we,
  input  logic        host_data_we,
  input  logic [31:0] host_wdata,
  output logic [31:0] vpd_addr_q,
  output logic [31:0] vpd_data_q,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int BAW = AW + 1;
  localparam int FW  = 3 + AW + 16;
  localparam int LW  = $clog2(FW + 1);

  logic [1:0]     rst_pipe_q;
  logic           rst_core_n;
  logic           flag_q, flag_d;
  logic [BAW-1:0] baddr_q, baddr_d;
  logic [31:0]    data_q, data_d;
  logic           accept;
  logic           rise_tick, fall_tick;
  logic           go_frame, go_poll, eng_done;
  logic [FW-1:0]  tx_vec;
  logic [LW-1:0]  tx_len;
  logic [15:0]    rx_word;
  logic           seq_busy, seq_done, rd_load, rd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign accept = host_addr_we && !seq_busy;

  always_comb begin
    flag_d  = flag_q;
    baddr_d = baddr_q;
    data_d  = data_q;
    if (accept) begin
      flag_d  = host_wdata[31];
      baddr_d = host_wdata[BAW-1:0];
    end else if (seq_done) begin
      flag_d = ~flag_q;
    end
    if (host_data_we && !seq_busy) begin
      data_d = host_wdata;
    end else if (rd_load) begin
      if (rd_hi) data_d[31:16] = rx_word;
      else       data_d[15:0]  = rx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      flag_q  <= 1'b0;
      baddr_q <= '0;
      data_q  <= '0;
    end else begin
      flag_q  <= flag_d;
      baddr_q <= baddr_d;
      data_q  <= data_d;
    end
  end

  assign vpd_addr_q = {flag_q, {(31-BAW){1'b0}}, baddr_q};
  assign vpd_data_q = data_q;

  vpd_sk_gen #(.DIV(DIV)) u_sk (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sk        (ee_sk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  vpd_seq #(.AW(AW), .FW(FW), .LW(LW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (accept),
    .dir_wr    (host_wdata[31]),
    .base_addr (host_wdata[AW:1]),
    .wdata     (data_q),
    .eng_done  (eng_done),
    .go_frame  (go_frame),
    .go_poll   (go_poll),
    .tx_vec    (tx_vec),
    .tx_len    (tx_len),
    .busy      (seq_busy),
    .done      (seq_done),
    .rd_load   (rd_load),
    .rd_hi     (rd_hi)
  );

  vpd_uwire #(.FW(FW), .LW(LW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .go_frame  (go_frame),
    .go_poll   (go_poll),
    .tx_vec    (tx_vec),
    .tx_len    (tx_len),
    .ee_do     (ee_do),
    .cs        (ee_cs),
    .di        (ee_di),
    .rx_word   (rx_word),
    .done      (eng_done)
  );
endmodule

// File: rtl/vpd_bridge_chk.sv
module vpd_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_addr_we,
  input logic [31:0] host_wdata,
  input logic [31:0] vpd_addr_q,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di,
  input logic        busy,
  input logic        seq_done
);
  logic last_cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     last_cmd_q <= 1'b0;
    else if (host_addr_we && !busy) last_cmd_q <= host_wdata[31];
  end

  // R9: data-in moves only with a falling serial clock
  a_r9_di_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_di != $past(ee_di)) |-> $fell(ee_sk));

  // R9: chip select moves only with a falling serial clock
  a_r9_cs_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs != $past(ee_cs)) |-> $fell(ee_sk));

  // R10
  a_r10_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ee_cs);

  // R8
  a_r8_ignore_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr_we && busy && !seq_done) |=> $stable(vpd_addr_q));

  // R11
  a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vpd_addr_q[31] == last_cmd_q));

  // R2 and R3: completion flips the flag against the command
  a_r3_done_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (vpd_addr_q[31] == !last_cmd_q));
endmodule

bind vpd_eeprom_bridge vpd_bridge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .host_addr_we (host_addr_we),
  .host_wdata   (host_wdata),
  .vpd_addr_q   (vpd_addr_q),
  .ee_cs        (ee_cs),
  .ee_sk        (ee_sk),
  .ee_di        (ee_di),
  .busy         (seq_busy),
  .seq_done     (seq_done)
);

// File: tb/vpd_eeprom_bridge_test.sv
`timescale 1ns/1ps
module vpd_eeprom_bridge_test;
  localparam int AW  = 6;
  localparam int DIV = 8;
  localparam int NW  = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_addr_we = 1'b0;
  logic        host_data_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] vpd_addr_q, vpd_data_q;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b1;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  vpd_eeprom_bridge #(.AW(AW), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr_we(host_addr_we),
    .host_data_we(host_data_we), .host_wdata(host_wdata),
    .vpd_addr_q(vpd_addr_q), .vpd_data_q(vpd_data_q),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'hA5C3 ^ 16'(i * 16'h0457);
  endfunction

  // Behavioural serial EEPROM
  logic [15:0] mem [NW];
  bit          m_init = 1'b0;
  bit          m_wen = 1'b0, m_started = 1'b0, m_rd = 1'b0;
  int          m_busy = 0, m_bits = 0;
  logic [7:0]  m_cmd = '0;
  logic [15:0] m_din = '0, m_rdw = '0;
  int          ewen_cnt = 0, order_err = 0;

  always @(posedge ee_sk) begin
    if (!m_init) begin
      for (int i = 0; i < NW; i++) mem[i] = pat(i);
      m_init = 1'b1;
    end
    if (m_busy > 0) m_busy--;
    if (!ee_cs) begin
      m_started = 1'b0; m_bits = 0; m_rd = 1'b0;
    end else if (m_rd) begin
      m_rdw = {m_rdw[14:0], 1'b0};
    end else if (!m_started) begin
      if (ee_di) begin
        m_started = 1'b1; m_bits = 1; m_cmd = '0;
        if (m_busy > 0) order_err++;
      end
    end else if (m_bits < 9) begin
      m_cmd = {m_cmd[6:0], ee_di};
      m_bits++;
      if (m_bits == 9) begin
        case (m_cmd[7:6])
          2'b10: begin m_rd = 1'b1; m_rdw = mem[m_cmd[5:0]]; end
          2'b00: if (m_cmd[5:4] == 2'b11) begin m_wen = 1'b1; ewen_cnt++; end
          default: ;
        endcase
      end
    end else if (m_bits < 25) begin
      m_din = {m_din[14:0], ee_di};
      m_bits++;
      if (m_bits == 25 && m_cmd[7:6] == 2'b01) begin
        if (m_wen) begin mem[m_cmd[5:0]] = m_din; m_busy = 6; end
        m_wen = 1'b0;
      end
    end
    ee_do <= m_rd ? m_rdw[15] : (m_busy == 0);
  end

  logic [15:0] exp_mem [NW];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_data(input logic [31:0] d);
    @(negedge clk); host_data_we = 1'b1; host_wdata = d;
    @(negedge clk); host_data_we = 1'b0; host_wdata = '0;
  endtask

  task automatic wr_addr(input logic fl, input logic [6:0] ba);
    @(negedge clk); host_addr_we = 1'b1;
    host_wdata = {fl, 24'($urandom), ba};
    @(negedge clk); host_addr_we = 1'b0; host_wdata = '0;
  endtask

  task automatic wait_flag(input logic v, input string req);
    int n = 0;
    while (vpd_addr_q[31] !== v && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, req, {31'd0, vpd_addr_q[31]}, {31'd0, v});
  endtask

  task automatic do_write(input logic [6:0] ba, input logic [31:0] d);
    logic [5:0] w0 = ba[6:1];
    logic [5:0] w1 = ba[6:1] + 6'd1;
    int e0 = ewen_cnt;
    wr_data(d);
    wr_addr(1'b1, ba);
    repeat (20) @(negedge clk);
    chk(vpd_addr_q[31] === 1'b1, "R11 write flag held", {31'd0, vpd_addr_q[31]}, 32'd1);
    wait_flag(1'b0, "R2 write completion");
    exp_mem[w0] = d[15:0];
    exp_mem[w1] = d[31:16];
    chk(vpd_addr_q === {25'd0, ba}, "R4 address readback", vpd_addr_q, {25'd0, ba});
    chk(vpd_data_q === d, "R2 data kept", vpd_data_q, d);
    chk(mem[w0] === d[15:0], "R2 low word stored", {16'd0, mem[w0]}, {16'd0, d[15:0]});
    chk(mem[w1] === d[31:16], "R2 high word stored", {16'd0, mem[w1]}, {16'd0, d[31:16]});
    chk(ewen_cnt == e0 + 2, "R6 enable frames", ewen_cnt, e0 + 2);
    chk(order_err == 0, "R7 frame before ready", order_err, 0);
    chk(ee_cs === 1'b0, "R10 cs idle", {31'd0, ee_cs}, 32'd0);
  endtask

  task automatic do_read(input logic [6:0] ba);
    logic [5:0] w0 = ba[6:1];
    logic [5:0] w1 = ba[6:1] + 6'd1;
    logic [31:0] e;
    wr_addr(1'b0, ba);
    repeat (20) @(negedge clk);
    chk(vpd_addr_q[31] === 1'b0, "R11 read flag held", {31'd0, vpd_addr_q[31]}, 32'd0);
    wait_flag(1'b1, "R3 read completion");
    e = {exp_mem[w1], exp_mem[w0]};
    chk(vpd_data_q === e, "R3 R5 read data", vpd_data_q, e);
    chk(ee_cs === 1'b0, "R10 cs idle", {31'd0, ee_cs}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int hi, per;
    logic [31:0] d1;
    void'($urandom(32'd2024));
    for (int i = 0; i < NW; i++) exp_mem[i] = pat(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(vpd_addr_q === 32'd0, "R1 address reset", vpd_addr_q, 32'd0);
    chk(vpd_data_q === 32'd0, "R1 data reset", vpd_data_q, 32'd0);
    chk(ee_cs === 1'b0, "R1 cs reset", {31'd0, ee_cs}, 32'd0);

    // R9 serial clock shape
    @(posedge ee_sk); @(negedge clk);
    hi = 0;
    while (ee_sk) begin hi++; @(negedge clk); end
    per = hi;
    while (!ee_sk) begin per++; @(negedge clk); end
    chk(hi == DIV / 2, "R9 sk high time", hi, DIV / 2);
    chk(per == DIV, "R9 sk period", per, DIV);

    // Directed cases
    do_write(7'h10, 32'hDEADBEEF);
    do_read(7'h10);
    do_read(7'h11);                       // R4 odd byte address
    do_write(7'h7F, 32'h12345678);        // R4 wrap to word 0
    do_read(7'h7E);
    do_read(7'h00);
    do_write(7'h20, 32'hFFFFFFFF);
    do_write(7'h22, 32'h00000000);
    do_read(7'h20);
    do_read(7'h22);

    // R8: commands during a running store are ignored
    d1 = 32'hCAFE0135;
    wr_data(d1);
    wr_addr(1'b1, 7'h30);
    repeat (40) @(negedge clk);
    wr_data(32'h55AA55AA);
    wr_addr(1'b0, 7'h40);
    chk(vpd_addr_q === {1'b1, 24'd0, 7'h30}, "R8 address kept", vpd_addr_q, {1'b1, 24'd0, 7'h30});
    chk(vpd_data_q === d1, "R8 data kept", vpd_data_q, d1);
    wait_flag(1'b0, "R8 store finishes");
    exp_mem[6'h18] = d1[15:0];
    exp_mem[6'h19] = d1[31:16];
    chk(vpd_addr_q === {25'd0, 7'h30}, "R8 second command dropped", vpd_addr_q, {25'd0, 7'h30});
    chk(vpd_data_q === d1, "R8 data after store", vpd_data_q, d1);
    do_read(7'h30);
    do_read(7'h40);

    // Random mix
    for (int k = 0; k < 12; k++) begin
      logic [6:0] ba = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 1) == 1) do_write(ba, $urandom);
      else                           do_read(ba);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule